// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block performs the bus work a small 8-bit CPU does when it takes or leaves an interrupt. It watches two active-low request lines. One is maskable and sensed as a level. The other is non-maskable and sensed on its falling edge. Requests are only taken at an instruction boundary, which is signalled by a strobe from the execution logic. That logic is not part of this block. It appears only as a current-PC input, a register snapshot input and the boundary and return strobes.

On entry the block saves a frame to a stack that lives in page 0x01 of memory. It writes one byte per cycle, with R/W low and VMA high. It then reads a two-byte vector, low byte first, and presents the result as a new program counter. On a return strobe it reads the frame back in reverse order. It then hands the saved registers, the saved return address and the saved mask back to the execution logic.

While a maskable interrupt is being serviced, further maskable requests are ignored. A non-maskable request is always taken, even inside another non-maskable handler, so frames nest on the stack.

Top module: `irq_sequencer`

## Requirements
- R1: After reset, busy=0, vma=0, rw=1, pc_load=0 and irq_active=0. The stack pointer starts at 0xFF.
- R2: An accepted entry writes 3+NREG bytes in consecutive cycles with rw=0 and vma=1. Each write goes to address {0x01, sp}, and sp decrements after each write. The byte order is: return-address high byte, return-address low byte, flag byte, then register bytes 0 to NREG-1, where byte i is regs_in[8i+7:8i]. The return address is cur_pc+1.
- R3: After the pushes the block reads the vector low byte and then the high byte in two consecutive cycles (rw=1). The vector is at 0xFFFA/0xFFFB for the non-maskable request and at 0xFFFE/0xFFFF for the maskable one. In the next cycle pc_load pulses for one cycle, with pc_new set to {high, low}.
- R4: The maskable request is taken only when irq_n is low during a cycle in which boundary=1 and irq_active=0. A low pulse that ends before a boundary has no effect. Taking it sets irq_active together with pc_load.
- R5: While irq_active=1, a boundary with irq_n low starts no bus cycle.
- R6: A falling edge of nmi_n is remembered until the next boundary, even if it arrives while the block is busy. Holding nmi_n low does not request again.
- R7: A non-maskable request is taken whatever the value of irq_active, including inside another non-maskable handler. It leaves irq_active unchanged.
- R8: When both requests are pending at the same boundary, the non-maskable one is taken.
- R9: On rti the block reads the frame back from {0x01, sp+1}, incrementing sp before each read, in the reverse of the push order. After the last read it pulses pc_load and rest_valid for one cycle. At that point pc_new holds the saved return address, rest_regs holds the saved registers and irq_active is restored from bit 0 of the flag byte.
- R10: When rti and boundary are both high in one idle cycle, the return is performed and the pending request stays for a later boundary.
- R11: The flag byte is {7'b0, irq_active}, taken at the moment of entry.
- R12: boundary and rti are ignored while busy=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_n | input | 1 | Maskable request, active low, level |
| nmi_n | input | 1 | Non-maskable request, active low, falling edge |
| boundary | input | 1 | Instruction boundary strobe |
| rti | input | 1 | Return-from-interrupt strobe |
| cur_pc | input | 16 | Address of the current instruction |
| regs_in | input | 8*NREG | Register snapshot to save |
| addr | output | 16 | Bus address |
| wdata | output | 8 | Write data |
| rdata | input | 8 | Read data, valid in the same cycle as addr |
| rw | output | 1 | 1 = read, 0 = write |
| vma | output | 1 | Bus cycle valid |
| pc_load | output | 1 | One-cycle strobe to load pc_new |
| pc_new | output | 16 | New program counter |
| rest_regs | output | 8*NREG | Registers restored by a return |
| rest_valid | output | 1 | One-cycle strobe for rest_regs |
| busy | output | 1 | A sequence is in progress |
| irq_active | output | 1 | Maskable handler in service |

## Verification
Two kinds of event can land in the same cycle. The first is a return strobe together with an instruction boundary that carries a live maskable request; the bench expects the pop sequence to run and the request to be taken at a later boundary. The second is a falling edge of the non-maskable line, paired with a boundary, in the middle of a pop. That boundary must start nothing, and the remembered edge must be taken at the next idle boundary. A further case puts a fresh non-maskable edge in the same cycle as a boundary while a maskable request is also low; the non-maskable vector must be fetched. Every bus cycle is compared against a stack and mask model kept in the bench, under both directed and randomly ordered nesting.

// File: rtl/irq_sequencer.sv
module irq_sequencer #(
  parameter int NREG = 3,
  parameter logic [7:0] SP_INIT = 8'hFF,
  parameter logic [15:0] NMI_VEC = 16'hFFFA,
  parameter logic [15:0] IRQ_VEC = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_n,
  input  logic              nmi_n,
  input  logic              boundary,
  input  logic              rti,
  input  logic [15:0]       cur_pc,
  input  logic [8*NREG-1:0] regs_in,
  output logic [15:0]       addr,
  output logic [7:0]        wdata,
  input  logic [7:0]        rdata,
  output logic              rw,
  output logic              vma,
  output logic              pc_load,
  output logic [15:0]       pc_new,
  output logic [8*NREG-1:0] rest_regs,
  output logic              rest_valid,
  output logic              busy,
  output logic              irq_active
);
  localparam int F  = 3 + NREG;
  localparam int FB = 8 * F;
  localparam int CW = $clog2(F + 1);
  localparam logic [CW-1:0] LAST = CW'(F - 1);

  typedef enum logic [2:0] {S_IDLE, S_PUSH, S_VLO, S_VHI, S_POP} st_t;

  st_t           st;
  logic [7:0]    sp, vlo;
  logic [CW-1:0] cnt;
  logic [FB-1:0] frm;
  logic          nmi_q, nmi_pend, take_nmi, mask;

  wire idle     = (st == S_IDLE);
  wire nmi_fall = nmi_q & ~nmi_n;
  wire nmi_req  = nmi_pend | nmi_fall;
  wire irq_req  = ~irq_n & ~mask;
  wire go_rti   = idle & rti;
  wire go_int   = idle & boundary & ~rti & (nmi_req | irq_req);
  wire [15:0] vec = take_nmi ? NMI_VEC : IRQ_VEC;
  wire [15:0] ret = cur_pc + 16'd1;

  assign busy       = ~idle;
  assign vma        = ~idle;
  assign rw         = (st != S_PUSH);
  assign irq_active = mask;
  assign wdata      = (st == S_PUSH) ? frm[{cnt, 3'b000} +: 8] : 8'h00;

  always_comb begin
    case (st)
      S_PUSH:  addr = {8'h01, sp};
      S_POP:   addr = {8'h01, sp + 8'd1};
      S_VLO:   addr = vec;
      S_VHI:   addr = vec + 16'd1;
      default: addr = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sp <= SP_INIT; cnt <= '0; frm <= '0; vlo <= 8'h00;
      nmi_q <= 1'b1; nmi_pend <= 1'b0; take_nmi <= 1'b0; mask <= 1'b0;
      pc_load <= 1'b0; pc_new <= 16'h0000; rest_regs <= '0; rest_valid <= 1'b0;
    end else begin
      nmi_q      <= nmi_n;
      nmi_pend   <= (go_int & nmi_req) ? 1'b0 : nmi_req;
      pc_load    <= 1'b0;
      rest_valid <= 1'b0;
      case (st)
        S_IDLE:
          if (go_rti) begin
            st <= S_POP; cnt <= LAST;
          end else if (go_int) begin
            st <= S_PUSH; cnt <= '0; take_nmi <= nmi_req;
            frm <= {regs_in, 7'b0, mask, ret[7:0], ret[15:8]};
          end
        S_PUSH: begin
          sp <= sp - 8'd1;
          if (cnt == LAST) st <= S_VLO;
          else cnt <= cnt + 1'b1;
        end
        S_VLO: begin vlo <= rdata; st <= S_VHI; end
        S_VHI: begin
          pc_new <= {rdata, vlo}; pc_load <= 1'b1; st <= S_IDLE;
          if (!take_nmi) mask <= 1'b1;
        end
        S_POP: begin
          sp <= sp + 8'd1;
          frm[{cnt, 3'b000} +: 8] <= rdata;
          if (cnt == '0) begin
            pc_new <= {rdata, frm[15:8]}; mask <= frm[16];
            rest_regs <= frm[FB-1:24]; rest_valid <= 1'b1; pc_load <= 1'b1;
            st <= S_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_push_descends: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_PUSH |=> sp == $past(sp) - 8'd1);
  a_r2_write_in_stack: assert property (@(posedge clk) disable iff (!rst_n)
    !rw |-> vma && addr[15:8] == 8'h01);
  a_r9_pop_ascends: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_POP |=> sp == $past(sp) + 8'd1);
  a_r3_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !pc_load);
  a_r5_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    idle && boundary && !rti && !nmi_req && mask |=> !busy);
  a_r8_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
    idle && boundary && !rti && nmi_req && !irq_n |=> take_nmi);
  a_r7_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_VHI && take_nmi |=> irq_active == $past(irq_active));
  a_r6_edge_held: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nmi_n) && !(idle && boundary && !rti) |=> nmi_pend);
  a_r10_rti_first: assert property (@(posedge clk) disable iff (!rst_n)
    idle && rti |=> st == S_POP);
  a_r12_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_PUSH && cnt != LAST |=> st == S_PUSH);
endmodule

// File: tb/irq_sequencer_test.sv
`timescale 1ns/1ps
module irq_sequencer_test;
  localparam logic [15:0] NV = 16'hC35A, IV = 16'h9E21;
  logic clk = 0, rst_n = 0, irq_n = 1, nmi_n = 1, boundary = 0, rti = 0;
  logic [15:0] cur_pc = 0, addr, pc_new;
  logic [23:0] regs_in = 0, rest_regs;
  logic [7:0] wdata, rdata;
  logic rw, vma, pc_load, rest_valid, busy, irq_active;
  logic [7:0] stk [256];
  logic [7:0] sp_m = 8'hFF;
  logic mask_m = 0;
  logic [15:0] m_pc [16];
  logic m_mask [16];
  logic [23:0] m_regs [16];
  int depth = 0, n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_sequencer uut (.clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n),
    .boundary(boundary), .rti(rti), .cur_pc(cur_pc), .regs_in(regs_in),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rw(rw), .vma(vma),
    .pc_load(pc_load), .pc_new(pc_new), .rest_regs(rest_regs),
    .rest_valid(rest_valid), .busy(busy), .irq_active(irq_active));

  always @(posedge clk) if (vma && !rw) stk[addr[7:0]] <= wdata;
  always_comb begin
    if (addr[15:8] == 8'h01) rdata = stk[addr[7:0]];
    else case (addr)
      16'hFFFA: rdata = NV[7:0];
      16'hFFFB: rdata = NV[15:8];
      16'hFFFE: rdata = IV[7:0];
      16'hFFFF: rdata = IV[15:8];
      default:  rdata = 8'h00;
    endcase
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin n_bad++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask

  task automatic enter(input bit nmi);
    logic [15:0] pc, ret, v, vv;
    logic [23:0] rg;
    logic [7:0] b [6];
    pc = 16'($urandom); rg = 24'($urandom); ret = pc + 16'd1;
    b[0] = ret[15:8]; b[1] = ret[7:0]; b[2] = {7'b0, mask_m};
    for (int i = 0; i < 3; i++) b[3+i] = rg[8*i +: 8];
    cur_pc = pc; regs_in = rg; boundary = 1;
    @(negedge clk); boundary = 0; regs_in = 24'($urandom);
    for (int k = 0; k < 6; k++) begin
      chk(addr == {8'h01, sp_m} && wdata == b[k] && !rw && vma,
          (k == 2) ? "R11 flag byte" : "R2 push", {addr, wdata}, {8'h01, sp_m, b[k]});
      sp_m--;
      @(negedge clk);
    end
    v = nmi ? 16'hFFFA : 16'hFFFE; vv = nmi ? NV : IV;
    chk(rw && vma && addr == v, "R3 vector low", addr, v);
    @(negedge clk);
    chk(rw && vma && addr == v + 16'd1, "R3 vector high", addr, v + 16'd1);
    @(negedge clk);
    chk(pc_load && !busy && pc_new == vv, "R3 pc load", pc_new, vv);
    m_pc[depth] = ret; m_mask[depth] = mask_m; m_regs[depth] = rg; depth++;
    if (!nmi) mask_m = 1;
    chk(irq_active == mask_m, nmi ? "R7 mask unchanged" : "R4 mask set", irq_active, mask_m);
    @(negedge clk);
    chk(!pc_load, "R3 one-cycle load", pc_load, 0);
  endtask

  task automatic leave(input bit with_bnd, input bit poke);
    rti = 1; boundary = with_bnd;
    @(negedge clk); rti = 0; boundary = 0; depth--;
    for (int k = 5; k >= 0; k--) begin
      chk(rw && vma && addr == {8'h01, 8'(sp_m + 8'd1)}, with_bnd ? "R10 pop wins" : "R9 pop addr",
          addr, {8'h01, 8'(sp_m + 8'd1)});
      sp_m++;
      if (poke && k == 3) begin nmi_n = 0; boundary = 1; end
      if (poke && k == 2) boundary = 0;
      @(negedge clk);
    end
    chk(pc_load && rest_valid && pc_new == m_pc[depth], "R9 return pc", pc_new, m_pc[depth]);
    chk(rest_regs == m_regs[depth], "R9 regs", rest_regs, m_regs[depth]);
    mask_m = m_mask[depth];
    chk(irq_active == mask_m, "R9 mask restored", irq_active, mask_m);
    @(negedge clk);
    chk(!busy && !rest_valid, "R12 nothing started", {busy, rest_valid}, 0);
  endtask

  task automatic no_entry(input string tag);
    boundary = 1;
    @(negedge clk); boundary = 0;
    chk(!busy && !vma, tag, {busy, vma}, 0);
    @(negedge clk);
    chk(!busy && !vma && irq_active == mask_m, tag, {busy, vma, irq_active}, {2'b0, mask_m});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !vma && rw && !pc_load && !irq_active, "R1 reset",
        {busy, vma, rw, pc_load, irq_active}, 5'b00100);
    irq_n = 0; @(negedge clk); irq_n = 1;
    no_entry("R4 level only");
    irq_n = 0; enter(0);
    no_entry("R5 irq masked");
    nmi_n = 0; enter(1);
    nmi_n = 1; @(negedge clk); nmi_n = 0; enter(1);
    leave(0, 0); leave(0, 0);
    chk(irq_active == 1, "R7 inside irq", irq_active, 1);
    irq_n = 1; leave(0, 0);
    irq_n = 0; nmi_n = 1; @(negedge clk); nmi_n = 0; enter(1);
    chk(depth == 1, "R8 nmi first", depth, 1);
    enter(0);
    irq_n = 1; leave(0, 0); leave(0, 0);
    nmi_n = 1; @(negedge clk); nmi_n = 0; enter(1);
    irq_n = 0; leave(1, 0);
    enter(0);
    irq_n = 1; nmi_n = 1; leave(0, 1);
    enter(1);
    no_entry("R6 held low no retrigger");
    leave(0, 0);
    for (int it = 0; it < 300; it++) begin
      int a;
      a = int'($urandom_range(0, 2));
      if (a == 0 && depth < 12) begin
        irq_n = 1'($urandom); nmi_n = 1; @(negedge clk); nmi_n = 0; enter(1);
      end else if (a == 1 && depth < 12) begin
        irq_n = 0;
        if (mask_m) no_entry("R5 irq masked rnd");
        else enter(0);
      end else if (depth > 0) begin
        irq_n = 1; leave(0, 0);
      end
    end
    irq_n = 1;
    while (depth > 0) leave(0, 0);
    chk(sp_m == 8'hFF && !irq_active, "R9 stack drained", {sp_m, irq_active}, {8'hFF, 1'b0});
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule